// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Instruction Executor

This block is a small sequential processor core for an 8-bit accumulator machine with a 16-bit address space. It moves opcodes, immediate operands and stack data over one synchronous byte-wide memory port. The port makes at most one access per clock. Read data returns on the clock after the read is issued. The core runs a fixed subset of instructions:

- no-operation
- 16-bit immediate loads into the HL pair and into the stack pointer
- accumulator increment with flag update
- absolute jump, jump through HL, and subroutine call
- interrupt disable

A second opcode table is entered through a prefix byte. Every entry in that table is illegal in this subset.

The accumulator, flags, H, L, PC, SP and the interrupt-master-enable bit are all brought out as ports. A `retire` pulse marks the cycle in which the results of an instruction first appear on those ports. Any opcode the core does not recognise, in either table, stops it for good. A sticky flag is raised and the bus goes quiet. The reset values of PC and SP are parameters with the defaults given below.

Top module: `cpu8_core`

## Requirements
- R1: While reset is high and on the first cycle after it, PC is 0x0100, SP is 0xDFFF, the interrupt-enable bit is 0, and A, F, H and L are 0x00.
- R2: Each instruction begins with a read at PC, after which PC is PC+1. Opcode 0x00 changes nothing else. Every read is addressed at the current PC. A read and a write never happen in the same cycle. `retire` is high for exactly one cycle per completed instruction, and that cycle shows the instruction's results.
- R3: Opcode 0x21 reads two further bytes. The first goes to L and the second to H. PC ends three past the opcode.
- R4: Opcode 0x31 reads two further bytes and loads SP with them, low byte first. PC ends three past the opcode. For example, 0x31 0xFF 0xCF gives SP 0xCFFF.
- R5: Opcode 0x3C sets A to A+1 modulo 256. F bit 7 (Z) is set exactly when the result is zero. Bit 6 (N) is cleared. Bit 5 (H) is set exactly when the old low nibble was 0xF. Bit 4 (C) keeps its value. Bits 3..0 of F are always zero.
- R6: Opcode 0xC3 reads a little-endian 16-bit address and loads it into PC.
- R7: Opcode 0xE9 loads PC with H as the upper byte and L as the lower byte.
- R8: Opcode 0xCD reads a little-endian target. It pushes the address of the byte after its operands, then jumps to the target. The push lowers SP by two. It writes the high byte at SP-1 first and the low byte at SP-2 on the next cycle, so that a little-endian read at the new SP returns the pushed address.
- R9: Opcode 0xF3 clears the interrupt-enable bit, and no instruction sets it.
- R10: Opcode 0xCB reads one more byte at PC and advances PC again. Every byte in that second table is illegal.
- R11: An unrecognised opcode raises `illegal`, which stays high until reset. After that the core issues no reads or writes, `retire` stays low, and PC and the other registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Bus address for the current access |
| mem_rd | output | 1 | Read request; data arrives next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the previous cycle's read |
| reg_a | output | 8 | Accumulator |
| reg_f | output | 8 | Flags Z,N,H,C in bits 7..4 |
| reg_h | output | 8 | H register |
| reg_l | output | 8 | L register |
| reg_pc | output | 16 | Program counter |
| reg_sp | output | 16 | Stack pointer |
| ime | output | 1 | Interrupt-master-enable bit |
| retire | output | 1 | One-cycle pulse when an instruction completes |
| illegal | output | 1 | Sticky illegal-opcode halt flag |

## Verification
The bound checker watches the rules that hold at every clock edge. It checks:
- the reset values;
- that every read is addressed at PC;
- that reads and writes never overlap;
- that stack writes land just below SP and come as a back-to-back pair;
- that the low flag bits stay zero and the enable bit never rises;
- that a halted core stays silent and frozen.

Operand byte order, the arithmetic and flag results of the increment, the jump targets, the stacked return address, and the prefix path into the halt depend on program content. Only the bench's instruction sequences can show these. In the bench, an independent model predicts the state after each retired instruction.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int NIB_W  = DATA_W / 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Flag byte: Z, N, H, C in the upper nibble, lower nibble unused.
    typedef struct packed {
        logic             z;
        logic             n;
        logic             h;
        logic             c;
        logic [NIB_W-1:0] rsvd;
    } flags_t;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_IMM_USE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PFX_RD,
        ST_PFX_DEC,
        ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_LD_HL,
        OP_LD_SP,
        OP_INC_A,
        OP_JP,
        OP_JP_HL,
        OP_CALL,
        OP_DI,
        OP_PREFIX,
        OP_BAD
    } op_e;

    localparam byte_t OPC_NOP    = 8'h00;
    localparam byte_t OPC_LD_HL  = 8'h21;
    localparam byte_t OPC_LD_SP  = 8'h31;
    localparam byte_t OPC_INC_A  = 8'h3C;
    localparam byte_t OPC_JP     = 8'hC3;
    localparam byte_t OPC_PREFIX = 8'hCB;
    localparam byte_t OPC_CALL   = 8'hCD;
    localparam byte_t OPC_JP_HL  = 8'hE9;
    localparam byte_t OPC_DI     = 8'hF3;

    function automatic logic takes_imm16(op_e op);
        return (op == OP_LD_HL) || (op == OP_LD_SP) ||
               (op == OP_JP)    || (op == OP_CALL);
    endfunction

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  byte_t opcode,
    input  logic  second_table,
    output op_e   op
);
    always_comb begin
        op = OP_BAD;
        if (!second_table) begin
            case (opcode)
                OPC_NOP:    op = OP_NOP;
                OPC_LD_HL:  op = OP_LD_HL;
                OPC_LD_SP:  op = OP_LD_SP;
                OPC_INC_A:  op = OP_INC_A;
                OPC_JP:     op = OP_JP;
                OPC_PREFIX: op = OP_PREFIX;
                OPC_CALL:   op = OP_CALL;
                OPC_JP_HL:  op = OP_JP_HL;
                OPC_DI:     op = OP_DI;
                default:    op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/cpu8_inc.sv
module cpu8_inc
    import cpu8_pkg::*;
(
    input  byte_t  a_in,
    input  flags_t f_in,
    output byte_t  a_out,
    output flags_t f_out
);
    always_comb begin
        a_out      = a_in + byte_t'(1);
        f_out.z    = (a_out == '0);
        f_out.n    = 1'b0;
        f_out.h    = &a_in[NIB_W-1:0];
        f_out.c    = f_in.c;
        f_out.rsvd = '0;
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0100,
    parameter logic [15:0] RESET_SP = 16'hDFFF
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  reg_a,
    output logic [7:0]  reg_f,
    output logic [7:0]  reg_h,
    output logic [7:0]  reg_l,
    output logic [15:0] reg_pc,
    output logic [15:0] reg_sp,
    output logic        ime,
    output logic        retire,
    output logic        illegal
);
    state_e state_q;
    op_e    op_q, dec_op;
    addr_t  pc_q, sp_q, tgt_q;
    byte_t  a_q, h_q, l_q, lo_q, inc_a;
    flags_t f_q, inc_f;
    logic   ime_q, retire_q, illegal_q;
    addr_t  imm16;

    cpu8_decode u_dec (
        .opcode       (mem_rdata),
        .second_table (state_q == ST_PFX_DEC),
        .op           (dec_op)
    );

    cpu8_inc u_inc (
        .a_in  (a_q),
        .f_in  (f_q),
        .a_out (inc_a),
        .f_out (inc_f)
    );

    assign imm16 = {mem_rdata, lo_q};

    // Bus side: one access per cycle, address from PC or from the stack.
    always_comb begin
        mem_rd    = (state_q == ST_FETCH) || (state_q == ST_IMM_LO) ||
                    (state_q == ST_IMM_HI) || (state_q == ST_PFX_RD);
        mem_wr    = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
        mem_addr  = mem_wr ? (sp_q - addr_t'(1)) : pc_q;
        mem_wdata = (state_q == ST_PUSH_HI) ? pc_q[ADDR_W-1:DATA_W]
                                            : pc_q[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_FETCH;
            op_q      <= OP_NOP;
            pc_q      <= RESET_PC;
            sp_q      <= RESET_SP;
            tgt_q     <= '0;
            a_q       <= '0;
            f_q       <= '0;
            h_q       <= '0;
            l_q       <= '0;
            lo_q      <= '0;
            ime_q     <= 1'b0;
            retire_q  <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            retire_q <= 1'b0;
            case (state_q)
                ST_FETCH: begin
                    pc_q    <= pc_q + addr_t'(1);
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    op_q    <= dec_op;
                    state_q <= ST_FETCH;
                    if (takes_imm16(dec_op)) begin
                        state_q <= ST_IMM_LO;
                    end else begin
                        case (dec_op)
                            OP_NOP:    retire_q <= 1'b1;
                            OP_INC_A: begin
                                a_q      <= inc_a;
                                f_q      <= inc_f;
                                retire_q <= 1'b1;
                            end
                            OP_JP_HL: begin
                                pc_q     <= {h_q, l_q};
                                retire_q <= 1'b1;
                            end
                            OP_DI: begin
                                ime_q    <= 1'b0;
                                retire_q <= 1'b1;
                            end
                            OP_PREFIX: state_q <= ST_PFX_RD;
                            default: begin
                                illegal_q <= 1'b1;
                                state_q   <= ST_HALT;
                            end
                        endcase
                    end
                end
                ST_IMM_LO: begin
                    pc_q    <= pc_q + addr_t'(1);
                    state_q <= ST_IMM_HI;
                end
                ST_IMM_HI: begin
                    lo_q    <= mem_rdata;
                    pc_q    <= pc_q + addr_t'(1);
                    state_q <= ST_IMM_USE;
                end
                ST_IMM_USE: begin
                    state_q  <= ST_FETCH;
                    retire_q <= 1'b1;
                    case (op_q)
                        OP_LD_HL: begin
                            h_q <= imm16[ADDR_W-1:DATA_W];
                            l_q <= imm16[DATA_W-1:0];
                        end
                        OP_LD_SP: sp_q <= imm16;
                        OP_JP:    pc_q <= imm16;
                        default: begin
                            tgt_q    <= imm16;
                            retire_q <= 1'b0;
                            state_q  <= ST_PUSH_HI;
                        end
                    endcase
                end
                ST_PUSH_HI: begin
                    sp_q    <= sp_q - addr_t'(1);
                    state_q <= ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    sp_q     <= sp_q - addr_t'(1);
                    pc_q     <= tgt_q;
                    retire_q <= 1'b1;
                    state_q  <= ST_FETCH;
                end
                ST_PFX_RD: begin
                    pc_q    <= pc_q + addr_t'(1);
                    state_q <= ST_PFX_DEC;
                end
                ST_PFX_DEC: begin
                    // Second table holds no legal entries in this subset.
                    if (dec_op == OP_BAD) begin
                        illegal_q <= 1'b1;
                        state_q   <= ST_HALT;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign reg_a   = a_q;
    assign reg_f   = f_q;
    assign reg_h   = h_q;
    assign reg_l   = l_q;
    assign reg_pc  = pc_q;
    assign reg_sp  = sp_q;
    assign ime     = ime_q;
    assign retire  = retire_q;
    assign illegal = illegal_q;

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk #(
    parameter logic [15:0] RESET_PC = 16'h0100,
    parameter logic [15:0] RESET_SP = 16'hDFFF
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [7:0]  reg_a,
    input logic [7:0]  reg_f,
    input logic [15:0] reg_pc,
    input logic [15:0] reg_sp,
    input logic        ime,
    input logic        retire,
    input logic        illegal
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_pc == RESET_PC && reg_sp == RESET_SP && !ime && reg_a == 8'h00));

    assert_single_access_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_read_at_pc_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> mem_addr == reg_pc);

    assert_flag_low_bits_R5: assert property (@(posedge clk) disable iff (rst)
        reg_f[3:0] == 4'h0 && !reg_f[4]);

    assert_push_below_sp_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr == reg_sp - 16'd1);

    assert_push_pair_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr) |=> mem_wr);

    assert_ime_never_set_R9: assert property (@(posedge clk) disable iff (rst)
        !$rose(ime));

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_rd && !mem_wr && !retire));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (illegal && $stable(reg_pc) && $stable(reg_sp)));
endmodule

bind cpu8_core cpu8_core_chk #(.RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_addr(mem_addr),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .reg_a   (reg_a),
    .reg_f   (reg_f),
    .reg_pc  (reg_pc),
    .reg_sp  (reg_sp),
    .ime     (ime),
    .retire  (retire),
    .illegal (illegal)
);

// File: tb/cpu8_core_test.sv
module cpu8_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  reg_a, reg_f, reg_h, reg_l;
    logic [15:0] reg_pc, reg_sp;
    logic        ime, retire, illegal;

    int errors = 0;
    int checks = 0;
    int bus_after_halt = 0;

    typedef struct {
        string       req;
        logic [15:0] pc, sp;
        logic [7:0]  a, f, h, l;
        logic        ie;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] mem [int];

    logic [15:0] m_pc, m_sp;
    logic [7:0]  m_a, m_f, m_h, m_l;
    logic        m_ie;

    cpu8_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_a(reg_a), .reg_f(reg_f), .reg_h(reg_h), .reg_l(reg_l),
        .reg_pc(reg_pc), .reg_sp(reg_sp), .ime(ime), .retire(retire),
        .illegal(illegal)
    );

    always #10 clk = ~clk;

    // Byte-wide synchronous memory model.
    always @(posedge clk) begin
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] peek(input logic [15:0] addr);
        return mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
    endfunction

    // Monitor: compare each retired instruction against the queue.
    always @(negedge clk) begin
        if (!rst && illegal && (mem_rd || mem_wr)) bus_after_halt++;
        if (!rst && retire) begin
            if (exp_q.size() == 0) begin
                check("R11", "unexpected retire", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "pc",  int'(reg_pc), int'(e.pc));
                check(e.req, "sp",  int'(reg_sp), int'(e.sp));
                check(e.req, "a",   int'(reg_a),  int'(e.a));
                check(e.req, "f",   int'(reg_f),  int'(e.f));
                check(e.req, "h",   int'(reg_h),  int'(e.h));
                check(e.req, "l",   int'(reg_l),  int'(e.l));
                check(e.req, "ime", int'(ime),    int'(e.ie));
            end
        end
    end

    // Driver side: place bytes, advance the model, queue the expectation.
    task automatic emit(input logic [7:0] b);
        mem[int'(m_pc)] = b;
        m_pc = m_pc + 16'd1;
    endtask

    task automatic push_exp(input string req);
        exp_t e;
        e.req = req; e.pc = m_pc; e.sp = m_sp; e.a = m_a; e.f = m_f;
        e.h = m_h; e.l = m_l; e.ie = m_ie;
        exp_q.push_back(e);
    endtask

    task automatic model_reset();
        m_pc = 16'h0100; m_sp = 16'hDFFF; m_a = 0; m_f = 0; m_h = 0; m_l = 0; m_ie = 0;
        exp_q.delete();
        mem.delete();
    endtask

    task automatic op_nop();
        emit(8'h00); push_exp("R2");
    endtask

    task automatic op_inc();
        logic hc;
        emit(8'h3C);
        hc  = (m_a[3:0] == 4'hF);
        m_a = m_a + 8'd1;
        m_f = {(m_a == 8'h00), 1'b0, hc, m_f[4], 4'h0};
        push_exp("R5");
    endtask

    task automatic op_ld_hl(input logic [15:0] v);
        emit(8'h21); emit(v[7:0]); emit(v[15:8]);
        m_h = v[15:8]; m_l = v[7:0];
        push_exp("R3");
    endtask

    task automatic op_ld_sp(input logic [15:0] v);
        emit(8'h31); emit(v[7:0]); emit(v[15:8]);
        m_sp = v;
        push_exp("R4");
    endtask

    task automatic op_di();
        emit(8'hF3); m_ie = 1'b0; push_exp("R9");
    endtask

    task automatic op_jp(input logic [15:0] t);
        emit(8'hC3); emit(t[7:0]); emit(t[15:8]);
        m_pc = t; push_exp("R6");
    endtask

    task automatic op_jp_hl();
        emit(8'hE9); m_pc = {m_h, m_l}; push_exp("R7");
    endtask

    task automatic op_call(input logic [15:0] t);
        emit(8'hCD); emit(t[7:0]); emit(t[15:8]);
        m_sp = m_sp - 16'd2;
        m_pc = t; push_exp("R8");
    endtask

    task automatic run_until_halt();
        for (int i = 0; i < 20000 && !illegal; i++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        check("WATCHDOG", "timeout", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Scenario 1: reset values, then the full instruction mix.
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "pc reset",  int'(reg_pc), 16'h0100);
        check("R1", "sp reset",  int'(reg_sp), 16'hDFFF);
        check("R1", "ime reset", int'(ime), 0);
        check("R1", "a/f/h/l reset", int'({reg_a, reg_f, reg_h, reg_l}), 0);

        op_inc();                 // A 00->01
        op_ld_hl(16'h1234);
        op_ld_sp(16'hCFFF);
        op_di();
        op_nop();
        op_jp(16'h0200);
        op_call(16'h484C);        // pushes 0x0203, SP -> 0xCFFD
        op_ld_hl(16'h300F);
        op_jp_hl();               // PC -> 0x300F
        for (int k = 0; k < 255; k++) op_inc();   // crosses nibble wraps and 0xFF->0x00
        emit(8'hCB); emit(8'h3C); // prefixed opcode: illegal
        rst = 1'b0;
        run_until_halt();

        check("R10", "illegal after prefix", int'(illegal), 1);
        check("R10", "pc after prefix pair", int'(reg_pc), 16'h3110);
        check("R8", "stacked high byte", int'(peek(16'hCFFE)), 8'h02);
        check("R8", "stacked low byte",  int'(peek(16'hCFFD)), 8'h03);
        check("R8", "little-endian read at SP",
              int'({peek(reg_sp + 16'd1), peek(reg_sp)}), 16'h0203);
        check("R5", "final A wraps to zero", int'(reg_a), 0);
        check("R5", "final flags Z and H", int'(reg_f), 8'hA0);
        check("R2", "retire count matches", exp_q.size(), 0);
        check("R11", "bus quiet after halt", bus_after_halt, 0);

        // Scenario 2: unknown first-table opcode halts right away.
        rst = 1'b1;
        model_reset();
        bus_after_halt = 0;
        repeat (3) @(negedge clk);
        check("R1", "pc re-reset", int'(reg_pc), 16'h0100);
        emit(8'hD3); emit(8'h00);
        rst = 1'b0;
        run_until_halt();
        check("R11", "illegal raised", int'(illegal), 1);
        check("R11", "pc frozen after opcode", int'(reg_pc), 16'h0101);
        check("R11", "no retire on illegal", exp_q.size(), 0);
        check("R11", "bus quiet after halt", bus_after_halt, 0);
        repeat (20) @(negedge clk);
        check("R11", "flag sticky", int'(illegal), 1);
        check("R11", "sp held", int'(reg_sp), 16'hDFFF);

        // Scenario 3: prefix followed by 0x00 is still illegal.
        rst = 1'b1;
        model_reset();
        bus_after_halt = 0;
        repeat (3) @(negedge clk);
        op_nop();
        emit(8'hCB); emit(8'h00);
        rst = 1'b0;
        run_until_halt();
        check("R10", "prefix 00 illegal", int'(illegal), 1);
        check("R10", "pc past prefix pair", int'(reg_pc), 16'h0103);
        check("R2", "nop retired", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule